// File: doc/BRIEF.md
# Ternary Search Table with Valid Tracking

This block is a small associative lookup table of `ENTRIES` words, each `WIDTH` bits wide. Every word has a mask of the same width and a two-bit occupancy state. A word can be written at an index given on the write port, or the block can place it in the lowest-numbered slot that is not live. A slot can be retired by an invalidate command. A retired slot keeps its bits, stops taking part in searches and can be written again.

A search has two steps. On the load strobe the block captures the key and the mode bit into a comparand register. In the next cycle all live words are compared against that register at once. In binary mode every bit must agree. In ternary mode the bits whose mask bit is set are left out of the comparison. The block registers three results: a hit flag, a flag for more than one hit, and the index of the winning slot, which is the lowest-numbered one. A table write or invalidate issued in the same cycle as the load does not change that search. A full flag shows when every slot is live, and an automatic write that finds no free slot is refused.

Top module: `tcam_table`

## Requirements
- R1: After reset every slot is empty (state code 2'b00), and full, srch_valid, srch_hit, srch_multi and wr_reject are all 0.
- R2: A write with wr_auto=0 stores wr_data and wr_mask into slot wr_idx and makes it live (code 2'b01), whatever state that slot had before.
- R3: A write with wr_auto=1 goes to the lowest index whose state is not live. An empty slot (2'b00) and a retired slot (2'b10) both count as free.
- R4: full is 1 exactly when every slot is live. An automatic write issued while full changes no slot, and wr_reject is 1 in the cycle after it. At all other times wr_reject is 0.
- R5: An invalidate of a live slot sets its code to 2'b10. From then on the slot matches no key and counts as free. An invalidate of a slot that is not live has no effect.
- R6: key and tern_mode are captured when key_load is 1. srch_valid is 1 for exactly the cycle after each load, and the results shown in that cycle depend only on the captured key, even if the key bus changes after the load.
- R7: With tern_mode=0 a slot hits only if every bit of its word equals the key. Its mask is ignored.
- R8: With tern_mode=1 a mask bit of 1 marks a don't-care position. The slot hits if all other positions are equal.
- R9: Only live slots can hit. Empty and retired slots never match.
- R10: srch_idx gives the lowest-numbered hitting slot. srch_multi is 1 when two or more slots hit. On a miss, srch_hit, srch_multi and srch_idx are all 0.
- R11: A search loaded in the same cycle as a write or an invalidate sees the table as it was before that change. A write and an invalidate to the same slot in the same cycle leave the slot live with the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| wr_auto | input | 1 | 1: write to the lowest free slot; 0: write to wr_idx |
| wr_idx | input | IDX_W | Target slot for an addressed write |
| wr_data | input | WIDTH | Word to store |
| wr_mask | input | WIDTH | Don't-care mask to store (1 = ignore the bit in ternary mode) |
| inv_en | input | 1 | Invalidate strobe |
| inv_idx | input | IDX_W | Slot to invalidate |
| key_load | input | 1 | Capture key and mode into the comparand register |
| key | input | WIDTH | Search key |
| tern_mode | input | 1 | 1: ternary compare; 0: binary compare |
| srch_valid | output | 1 | Results below are fresh this cycle |
| srch_hit | output | 1 | At least one live slot matched |
| srch_multi | output | 1 | Two or more live slots matched |
| srch_idx | output | IDX_W | Lowest matching slot index |
| full | output | 1 | Every slot is live |
| wr_reject | output | 1 | The automatic write of the previous cycle found no free slot |

## Verification
The search results are due two clock edges after the load strobe is driven. The first edge loads the comparand and the second registers the results. The bench therefore drives the strobe on a falling edge, changes the key bus to its inverse on the next falling edge, and samples on the falling edge after that. wr_reject and full are due one edge after the write is driven, and the bench samples them on the very next falling edge. It sweeps every key of a 6-bit, 8-slot table in both modes against an arithmetic reference model. The reference model is advanced in the same order the requirements give, with same-cycle searches evaluated before the write is applied.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  // occupancy code per slot; any code other than SLOT_LIVE is free for writes
  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'b00,
    SLOT_LIVE    = 2'b01,
    SLOT_RETIRED = 2'b10,
    SLOT_SPARE   = 2'b11
  } slot_state_e;

endpackage

// File: rtl/tcam_prio.sv
// lowest-index-first selector over a request vector
module tcam_prio #(
  parameter  int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end

endmodule

// File: rtl/tcam_match.sv
// parallel compare of the comparand against every slot view
module tcam_match #(
  parameter int N = 16,
  parameter int W = 32
) (
  input  logic [N-1:0][W-1:0] slot_data,
  input  logic [N-1:0][W-1:0] slot_mask,
  input  logic [N-1:0]        slot_live,
  input  logic [W-1:0]        cmp_key,
  input  logic                cmp_tern,
  output logic [N-1:0]        hit_vec,
  output logic                hit_multi
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] care;
    assign care       = cmp_tern ? ~slot_mask[g] : {W{1'b1}};
    assign hit_vec[g] = slot_live[g] & ~|((slot_data[g] ^ cmp_key) & care);
  end

  // clearing the lowest set bit leaves something only if two or more hit
  assign hit_multi = |(hit_vec & (hit_vec - 1'b1));

endmodule

// File: rtl/tcam_store.sv
// slot storage, occupancy tracking and the pre-write search view
module tcam_store
  import tcam_pkg::*;
#(
  parameter  int N  = 16,
  parameter  int W  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_auto,
  input  logic [IW-1:0]       wr_idx,
  input  logic [W-1:0]        wr_data,
  input  logic [W-1:0]        wr_mask,
  input  logic                inv_en,
  input  logic [IW-1:0]       inv_idx,
  input  logic                snap_en,
  output logic [N-1:0][W-1:0] view_data,
  output logic [N-1:0][W-1:0] view_mask,
  output logic [N-1:0]        view_live,
  output logic                full,
  output logic                wr_reject
);

  slot_state_e    st_q [N];
  slot_state_e    st_d [N];
  logic [W-1:0]   data_q [N];
  logic [W-1:0]   mask_q [N];
  logic [N-1:0]   slot_we;
  logic [N-1:0]   free_vec;
  logic           free_any;
  logic [IW-1:0]  free_idx;
  logic [IW-1:0]  tgt;
  logic           wr_go;
  logic           rej_d;
  logic           rej_q;

  // state seen by the search loaded in the same cycle
  logic [N-1:0]   live_snap_q;
  logic           sh_hit_q;
  logic [IW-1:0]  sh_idx_q;
  logic [W-1:0]   sh_data_q;
  logic [W-1:0]   sh_mask_q;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      free_vec[i] = (st_q[i] != SLOT_LIVE);
    end
  end

  tcam_prio #(.N(N)) u_free_pick (
    .req (free_vec),
    .any (free_any),
    .idx (free_idx)
  );

  // next-state for occupancy and write enables
  always_comb begin
    tgt   = wr_auto ? free_idx : wr_idx;
    wr_go = wr_en && (!wr_auto || free_any);
    rej_d = wr_en && wr_auto && !free_any;
    for (int i = 0; i < N; i++) begin
      st_d[i]    = st_q[i];
      slot_we[i] = 1'b0;
      if (inv_en && (inv_idx == IW'(i)) && (st_q[i] == SLOT_LIVE)) begin
        st_d[i] = SLOT_RETIRED;
      end
      if (wr_go && (tgt == IW'(i))) begin
        st_d[i]    = SLOT_LIVE;
        slot_we[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) st_q[i] <= SLOT_EMPTY;
      rej_q <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++) st_q[i] <= st_d[i];
      rej_q <= rej_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (slot_we[i]) begin
        data_q[i] <= wr_data;
        mask_q[i] <= wr_mask;
      end
    end
  end

  // snapshot of liveness and of the one slot a same-cycle write overwrites
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_snap_q <= '0;
      sh_hit_q    <= 1'b0;
      sh_idx_q    <= '0;
    end else if (snap_en) begin
      live_snap_q <= ~free_vec;
      sh_hit_q    <= wr_go;
      sh_idx_q    <= tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (snap_en) begin
      sh_data_q <= data_q[tgt];
      sh_mask_q <= mask_q[tgt];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (sh_hit_q && (sh_idx_q == IW'(i))) begin
        view_data[i] = sh_data_q;
        view_mask[i] = sh_mask_q;
      end else begin
        view_data[i] = data_q[i];
        view_mask[i] = mask_q[i];
      end
    end
  end

  assign view_live = live_snap_q;
  assign full      = ~|free_vec;
  assign wr_reject = rej_q;

  p_write_makes_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> (st_q[$past(tgt)] == SLOT_LIVE));

  p_auto_lands_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_auto && !full) |=> (st_q[$past(free_idx)] == SLOT_LIVE));

  p_inv_drops_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(wr_go && (tgt == inv_idx))) |=> (st_q[$past(inv_idx)] != SLOT_LIVE));

endmodule

// File: rtl/tcam_table.sv
module tcam_table
  import tcam_pkg::*;
#(
  parameter  int ENTRIES = 16,
  parameter  int WIDTH   = 32,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_auto,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             key_load,
  input  logic [WIDTH-1:0] key,
  input  logic             tern_mode,
  output logic             srch_valid,
  output logic             srch_hit,
  output logic             srch_multi,
  output logic [IDX_W-1:0] srch_idx,
  output logic             full,
  output logic             wr_reject
);

  logic [1:0]                    rsync_q;
  logic                          rst_int_n;
  logic [WIDTH-1:0]              cmp_key_q;
  logic                          cmp_tern_q;
  logic                          pend_q;
  logic [ENTRIES-1:0][WIDTH-1:0] view_data;
  logic [ENTRIES-1:0][WIDTH-1:0] view_mask;
  logic [ENTRIES-1:0]            view_live;
  logic [ENTRIES-1:0]            hit_vec;
  logic                          hit_multi;
  logic                          hit_any;
  logic [IDX_W-1:0]              hit_idx;
  logic                          res_hit_d;
  logic                          res_multi_d;
  logic [IDX_W-1:0]              res_idx_d;
  logic                          res_hit_q;
  logic                          res_multi_q;
  logic [IDX_W-1:0]              res_idx_q;
  logic                          res_valid_q;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // comparand register
  always_ff @(posedge clk) begin
    if (key_load) begin
      cmp_key_q  <= key;
      cmp_tern_q <= tern_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pend_q <= 1'b0;
    else            pend_q <= key_load;
  end

  tcam_store #(.N(ENTRIES), .W(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_auto   (wr_auto),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .inv_en    (inv_en),
    .inv_idx   (inv_idx),
    .snap_en   (key_load),
    .view_data (view_data),
    .view_mask (view_mask),
    .view_live (view_live),
    .full      (full),
    .wr_reject (wr_reject)
  );

  tcam_match #(.N(ENTRIES), .W(WIDTH)) u_match (
    .slot_data (view_data),
    .slot_mask (view_mask),
    .slot_live (view_live),
    .cmp_key   (cmp_key_q),
    .cmp_tern  (cmp_tern_q),
    .hit_vec   (hit_vec),
    .hit_multi (hit_multi)
  );

  tcam_prio #(.N(ENTRIES)) u_hit_pick (
    .req (hit_vec),
    .any (hit_any),
    .idx (hit_idx)
  );

  // result next-state: refresh only in the compare cycle
  always_comb begin
    res_hit_d   = res_hit_q;
    res_multi_d = res_multi_q;
    res_idx_d   = res_idx_q;
    if (pend_q) begin
      res_hit_d   = hit_any;
      res_multi_d = hit_multi;
      res_idx_d   = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_valid_q <= 1'b0;
      res_hit_q   <= 1'b0;
      res_multi_q <= 1'b0;
      res_idx_q   <= '0;
    end else begin
      res_valid_q <= pend_q;
      res_hit_q   <= res_hit_d;
      res_multi_q <= res_multi_d;
      res_idx_q   <= res_idx_d;
    end
  end

  assign srch_valid = res_valid_q;
  assign srch_hit   = res_hit_q;
  assign srch_multi = res_multi_q;
  assign srch_idx   = res_idx_q;

  p_reject_when_full_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_auto && full) |=> wr_reject);

  p_no_stray_reject_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(wr_en && wr_auto) |=> !wr_reject);

  p_valid_follows_load_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    key_load |=> ##1 srch_valid);

  p_valid_only_after_load_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!key_load && !pend_q) |=> !srch_valid);

  p_multi_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    srch_multi |-> srch_hit);

  p_miss_idx_zero_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (srch_valid && !srch_hit) |-> (srch_idx == '0));

endmodule

// File: tb/test_tcam_table.sv
module test_tcam_table;

  localparam int N  = 8;
  localparam int W  = 6;
  localparam int IW = 3;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic          wr_auto;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;
  logic [W-1:0]  wr_mask;
  logic          inv_en;
  logic [IW-1:0] inv_idx;
  logic          key_load;
  logic [W-1:0]  key;
  logic          tern_mode;
  logic          srch_valid;
  logic          srch_hit;
  logic          srch_multi;
  logic [IW-1:0] srch_idx;
  logic          full;
  logic          wr_reject;

  int n_run;
  int n_fail;

  // reference model: state 0 empty, 1 live, 2 retired
  logic [W-1:0] m_data [N];
  logic [W-1:0] m_mask [N];
  int           m_st   [N];

  tcam_table #(.ENTRIES(N), .WIDTH(W)) i_tcam_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_auto    (wr_auto),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .wr_mask    (wr_mask),
    .inv_en     (inv_en),
    .inv_idx    (inv_idx),
    .key_load   (key_load),
    .key        (key),
    .tern_mode  (tern_mode),
    .srch_valid (srch_valid),
    .srch_hit   (srch_hit),
    .srch_multi (srch_multi),
    .srch_idx   (srch_idx),
    .full       (full),
    .wr_reject  (wr_reject)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_full();
    for (int i = 0; i < N; i++) if (m_st[i] != 1) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (m_st[i] != 1) return i;
    return -1;
  endfunction

  function automatic logic [5:0] m_search(input logic [W-1:0] k, input bit tern);
    int cnt;
    int first;
    logic [W-1:0] care;
    cnt = 0;
    first = 0;
    for (int i = N - 1; i >= 0; i--) begin
      care = tern ? ~m_mask[i] : {W{1'b1}};
      if (m_st[i] == 1 && ((m_data[i] ^ k) & care) == '0) begin
        cnt++;
        first = i;
      end
    end
    return {1'b1, cnt > 0, cnt > 1, IW'(first)};
  endfunction

  function automatic void m_write(input int idx, input logic [W-1:0] d, input logic [W-1:0] m);
    m_data[idx] = d;
    m_mask[idx] = m;
    m_st[idx]   = 1;
  endfunction

  function automatic void m_inv(input int idx);
    if (m_st[idx] == 1) m_st[idx] = 2;
  endfunction

  task automatic do_search(input logic [W-1:0] k, input bit tern, input string req);
    logic [5:0] exp;
    logic [5:0] act;
    exp = m_search(k, tern);
    @(negedge clk);
    key = k; tern_mode = tern; key_load = 1'b1;
    @(negedge clk);
    key_load = 1'b0; key = ~k; tern_mode = ~tern;
    @(negedge clk);
    act = {srch_valid, srch_hit, srch_multi, srch_idx};
    chk(act == exp, req, "search {valid,hit,multi,idx}", 32'(act), 32'(exp));
  endtask

  task automatic sweep(input bit tern, input string req);
    for (int k = 0; k < (1 << W); k++) do_search(W'(k), tern, req);
  endtask

  task automatic do_write(input bit auto_w, input int idx, input logic [W-1:0] d,
                          input logic [W-1:0] m, input string req);
    int  t;
    bit  rej;
    t   = auto_w ? m_free() : idx;
    rej = (t < 0);
    @(negedge clk);
    wr_en = 1'b1; wr_auto = auto_w; wr_idx = IW'(idx); wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
    if (!rej) m_write(t, d, m);
    chk(wr_reject == rej, req, "wr_reject", 32'(wr_reject), 32'(rej));
    chk(full == m_full(), "R4", "full", 32'(full), 32'(m_full()));
  endtask

  task automatic do_inv(input int idx);
    @(negedge clk);
    inv_en = 1'b1; inv_idx = IW'(idx);
    @(negedge clk);
    inv_en = 1'b0;
    m_inv(idx);
    chk(full == m_full(), "R5", "full after invalidate", 32'(full), 32'(m_full()));
  endtask

  // search loaded together with a write and/or an invalidate (R11)
  task automatic same_cycle(input bit do_wr, input int widx, input logic [W-1:0] d,
                            input logic [W-1:0] m, input bit do_iv, input int iidx,
                            input logic [W-1:0] k, input bit tern);
    logic [5:0] exp;
    logic [5:0] act;
    exp = m_search(k, tern);
    @(negedge clk);
    key = k; tern_mode = tern; key_load = 1'b1;
    wr_en = do_wr; wr_auto = 1'b0; wr_idx = IW'(widx); wr_data = d; wr_mask = m;
    inv_en = do_iv; inv_idx = IW'(iidx);
    @(negedge clk);
    key_load = 1'b0; wr_en = 1'b0; inv_en = 1'b0; key = ~k;
    if (do_iv) m_inv(iidx);
    if (do_wr) m_write(widx, d, m);
    @(negedge clk);
    act = {srch_valid, srch_hit, srch_multi, srch_idx};
    chk(act == exp, "R11", "same-cycle search", 32'(act), 32'(exp));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0; m_data[i] = '0; m_mask[i] = '0;
    end
    rst_n = 1'b0;
    wr_en = 1'b0; wr_auto = 1'b0; wr_idx = '0; wr_data = '0; wr_mask = '0;
    inv_en = 1'b0; inv_idx = '0; key_load = 1'b0; key = '0; tern_mode = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(full == 1'b0, "R1", "full", 32'(full), 0);
    chk(srch_valid == 1'b0, "R1", "srch_valid", 32'(srch_valid), 0);
    chk(srch_hit == 1'b0 && srch_multi == 1'b0, "R1", "hit/multi", 32'({srch_hit, srch_multi}), 0);
    chk(wr_reject == 1'b0, "R1", "wr_reject", 32'(wr_reject), 0);
    do_search(6'h15, 1'b0, "R9");
    do_search(6'h00, 1'b1, "R9");

    // R3 fill with automatic writes
    do_write(1'b1, 0, 6'h15, 6'h00, "R3");
    do_write(1'b1, 0, 6'h15, 6'h03, "R3");
    do_write(1'b1, 0, 6'h2A, 6'h0F, "R3");
    do_write(1'b1, 0, 6'h00, 6'h00, "R3");
    do_write(1'b1, 0, 6'h3F, 6'h30, "R3");
    do_write(1'b1, 0, 6'h2A, 6'h00, "R3");
    do_write(1'b1, 0, 6'h11, 6'h3F, "R3");
    do_write(1'b1, 0, 6'h07, 6'h01, "R3");
    chk(full == 1'b1, "R4", "full after fill", 32'(full), 1);

    sweep(1'b0, "R7");
    sweep(1'b1, "R8");

    // R4 automatic write while full is refused and changes nothing
    do_write(1'b1, 0, 6'h3C, 6'h00, "R4");
    sweep(1'b0, "R4");

    // R5 retire two slots
    do_inv(2);
    do_inv(5);
    chk(full == 1'b0, "R5", "full after retire", 32'(full), 0);
    sweep(1'b1, "R5");

    // R3 retired slot 2 is the lowest free one
    do_write(1'b1, 0, 6'h3C, 6'h00, "R3");
    do_search(6'h3C, 1'b0, "R3");
    chk(srch_hit == 1'b1 && srch_idx == 3'd2, "R3", "auto write landed at slot 2",
        32'({srch_hit, srch_idx}), 32'({1'b1, 3'd2}));

    // R5 invalidate of a retired slot does nothing; R2 addressed write over retired slot
    do_inv(2);
    do_inv(2);
    do_write(1'b0, 5, 6'h15, 6'h00, "R2");
    do_write(1'b0, 3, 6'h21, 6'h00, "R2");
    sweep(1'b0, "R2");
    sweep(1'b1, "R10");

    // R11 same-cycle interactions
    same_cycle(1'b1, 0, 6'h22, 6'h00, 1'b0, 0, 6'h15, 1'b0);
    do_search(6'h15, 1'b0, "R11");
    same_cycle(1'b0, 0, 6'h00, 6'h00, 1'b1, 1, 6'h15, 1'b0);
    do_search(6'h15, 1'b0, "R11");
    same_cycle(1'b1, 3, 6'h09, 6'h00, 1'b1, 3, 6'h09, 1'b0);
    do_search(6'h09, 1'b0, "R11");
    chk(srch_hit == 1'b1 && srch_idx == 3'd3, "R11", "write wins over invalidate",
        32'({srch_hit, srch_idx}), 32'({1'b1, 3'd3}));

    sweep(1'b1, "R6");
    sweep(1'b0, "R10");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule